// File: doc/BRIEF.md
# Predicate Mask Lookup Unit

This block turns the register number that an instruction names into the predicate bit mask that governs its element operations. Software fills a small key-value configuration table of 16 entries through a write port. Each entry says that when a given integer or floating-point register is used, the element mask must be taken from another integer register. That register's content may be inverted. A zeroing flag travels with the mask.

The table is expanded into one slot per architectural register, 32 for the integer file and 32 for the floating-point file. A lookup picks a slot from a type flag and a register number, puts the stored mask-register index on a read port into the integer register file, and registers the result. The mask, the zeroing flag and a valid strobe appear one cycle after the request. A register that no entry names is unpredicated: every element is active, so the mask is all ones.

Top module: `pred_mask_lookup`

## Requirements
- R1: After reset every entry is inactive, so every lookup in either file returns a mask of all ones with the zeroing flag at 0.
- R2: A configuration word is 14 bits: bit 13 bank, bit 12 zeroing, bit 11 invert, bit 10 file select (0 integer, 1 float), bits 9..5 the keyed register, bits 4..0 the integer register that holds the mask.
- R3: An entry enables only the slot of its own file and keyed register; a lookup of any other slot, or of the same number in the other file, returns all ones.
- R4: For an enabled slot with invert clear, the mask equals the integer register named by the stored mask index, read through `rf_raddr`/`rf_rdata`.
- R5: For an enabled slot with invert set, every bit of the fetched register is inverted in the output mask.
- R6: `lk_zero` equals the zeroing bit of the matching entry, and is 0 when the slot is not enabled.
- R7: An entry with the bank bit set is reserved and enables no slot.
- R8: When two or more active entries key the same register in the same file, the entry with the highest table index decides the mask and flags.
- R9: A configuration write takes effect for a lookup requested in the next cycle, and an overwritten entry no longer enables the slot it named before.
- R10: `lk_valid` is high exactly in the cycle after a cycle with `lk_req` high; without a request `lk_mask` and `lk_zero` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Index of the entry written |
| cfg_wdata | input | 14 | Entry content, fields as in R2 |
| lk_req | input | 1 | Lookup request |
| lk_is_fp | input | 1 | Lookup file: 0 integer, 1 float |
| lk_reg | input | 5 | Architectural register used by the instruction |
| rf_raddr | output | 5 | Integer register file read address |
| rf_rdata | input | XLEN | Integer register file read data, same cycle |
| lk_valid | output | 1 | Lookup result valid |
| lk_mask | output | XLEN | Predicate mask |
| lk_zero | output | 1 | Masked-off elements are zeroed |

## Verification
The hardest situation to reach is several active entries fighting over one slot while reserved entries and entries of the other file name the same number, because only the resolved winner is visible at the ports. The stimulus fills the whole table with entries that all key one float register, with the bank bit set on the highest ones and integer entries keying the same number, then sweeps all 64 slots. Further phases sweep every slot after a reset, after a spread configuration with mixed invert and zeroing, and after overwriting entries so stale keys must vanish, with the first lookup issued in the cycle right after the last write.

// File: rtl/pred_lookup_pkg.sv
// Shared constants and types of the predicate mask lookup unit.
// Assumes a 32-register file per type and a 16-entry key-value table.
package pred_lookup_pkg;
    localparam int NUM_ENTRIES = 16;
    localparam int NUM_REGS    = 32;
    localparam int ENT_AW      = $clog2(NUM_ENTRIES);
    localparam int REG_AW      = $clog2(NUM_REGS);
    localparam int ENTRY_W     = 3 + 1 + 2 * REG_AW;

    // Field positions of a configuration word (decoded by the expansion)
    localparam int F_MASKREG_LO = 0;
    localparam int F_KEY_LO     = REG_AW;
    localparam int F_IS_FP      = 2 * REG_AW;
    localparam int F_INV        = F_IS_FP + 1;
    localparam int F_ZERO       = F_IS_FP + 2;
    localparam int F_BANK       = F_IS_FP + 3;

    // Reset value: bank bit set, which marks the entry as reserved/inactive
    localparam logic [ENTRY_W-1:0] ENTRY_RESET = ENTRY_W'(1) << F_BANK;

    // One expanded per-register slot
    typedef struct packed {
        logic              en;
        logic              zero;
        logic              inv;
        logic [REG_AW-1:0] idx;
    } slot_t;
endpackage

// File: rtl/pred_cfg_table.sv
// Configuration storage: NUM_ENTRIES words written one at a time.
// Assumes writes are single-cycle; every entry resets to the inactive value.
module pred_cfg_table
    import pred_lookup_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [ENT_AW-1:0]  waddr,
    input  logic [ENTRY_W-1:0] wdata,
    output logic [ENTRY_W-1:0] cfg_q [NUM_ENTRIES]
);
    // Store one entry per write, reset all entries to inactive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NUM_ENTRIES; e++) cfg_q[e] <= ENTRY_RESET;
        end else if (we) begin
            cfg_q[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/pred_expand.sv
// Turns the key-value table into one slot per register of one file.
// Assumes entries are scanned in ascending order so the highest match wins;
// entries with the bank bit set are reserved and never match.
module pred_expand
    import pred_lookup_pkg::*;
#(
    parameter bit FILE_SEL = 1'b0
) (
    input  logic [ENTRY_W-1:0] cfg_q [NUM_ENTRIES],
    output slot_t              tbl   [NUM_REGS]
);
    for (genvar s = 0; s < NUM_REGS; s++) begin : g_slot
        // Resolve which entry, if any, targets this slot
        always_comb begin
            tbl[s] = '0;
            for (int e = 0; e < NUM_ENTRIES; e++) begin
                if (!cfg_q[e][F_BANK] &&
                    cfg_q[e][F_IS_FP] == FILE_SEL &&
                    cfg_q[e][F_KEY_LO +: REG_AW] == REG_AW'(s)) begin
                    tbl[s].en   = 1'b1;
                    tbl[s].zero = cfg_q[e][F_ZERO];
                    tbl[s].inv  = cfg_q[e][F_INV];
                    tbl[s].idx  = cfg_q[e][F_MASKREG_LO +: REG_AW];
                end
            end
        end
    end
endmodule

// File: rtl/pred_mask_fetch.sv
// Reads the mask register of the selected slot and registers the result.
// Assumes the register file answers its read address in the same cycle.
module pred_mask_fetch
    import pred_lookup_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  slot_t             sel,
    output logic [REG_AW-1:0] rf_raddr,
    input  logic [XLEN-1:0]   rf_rdata,
    output logic              valid,
    output logic [XLEN-1:0]   mask,
    output logic              zero
);
    logic [XLEN-1:0] mask_d;

    // Address the register named by the slot
    assign rf_raddr = sel.idx;

    // Form the mask: all ones when unpredicated, optional inversion otherwise
    always_comb begin
        if (!sel.en)     mask_d = '1;
        else if (sel.inv) mask_d = ~rf_rdata;
        else             mask_d = rf_rdata;
    end

    // Register the result; hold it when no request is made
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            mask  <= '1;
            zero  <= 1'b0;
        end else begin
            valid <= req;
            if (req) begin
                mask <= mask_d;
                zero <= sel.en & sel.zero;
            end
        end
    end
endmodule

// File: rtl/pred_mask_lookup.sv
// Top of the predicate mask lookup unit: configuration table, one
// expansion per register file, slot select and registered mask fetch.
// Assumes a lookup in the same cycle as a write sees the previous table.
module pred_mask_lookup
    import pred_lookup_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ENT_AW-1:0]  cfg_addr,
    input  logic [ENTRY_W-1:0] cfg_wdata,
    input  logic               lk_req,
    input  logic               lk_is_fp,
    input  logic [REG_AW-1:0]  lk_reg,
    output logic [REG_AW-1:0]  rf_raddr,
    input  logic [XLEN-1:0]    rf_rdata,
    output logic               lk_valid,
    output logic [XLEN-1:0]    lk_mask,
    output logic               lk_zero
);
    logic [ENTRY_W-1:0] cfg_q [NUM_ENTRIES];
    slot_t              int_tbl [NUM_REGS];
    slot_t              fp_tbl  [NUM_REGS];
    slot_t              sel_slot;

    pred_cfg_table u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .waddr (cfg_addr),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    pred_expand #(.FILE_SEL(1'b0)) u_exp_int (.cfg_q(cfg_q), .tbl(int_tbl));
    pred_expand #(.FILE_SEL(1'b1)) u_exp_fp  (.cfg_q(cfg_q), .tbl(fp_tbl));

    // Pick the slot of the requested file and register
    assign sel_slot = lk_is_fp ? fp_tbl[lk_reg] : int_tbl[lk_reg];

    pred_mask_fetch #(.XLEN(XLEN)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (lk_req),
        .sel      (sel_slot),
        .rf_raddr (rf_raddr),
        .rf_rdata (rf_rdata),
        .valid    (lk_valid),
        .mask     (lk_mask),
        .zero     (lk_zero)
    );
endmodule

// File: rtl/pred_mask_lookup_chk.sv
// Checker for the predicate mask lookup unit, bound to the top.
// Relates the selected slot (from the expansion) to the registered outputs.
module pred_mask_lookup_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_req,
    input logic            sel_en,
    input logic            sel_inv,
    input logic            sel_zero,
    input logic [XLEN-1:0] rf_rdata,
    input logic            lk_valid,
    input logic [XLEN-1:0] lk_mask,
    input logic            lk_zero
);
    // R10
    valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_valid);
    // R10
    no_valid_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_valid);
    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> ($stable(lk_mask) && $stable(lk_zero)));
    // R3
    unpredicated_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !sel_en) |=> (lk_mask == {XLEN{1'b1}} && !lk_zero));
    // R4
    direct_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && sel_en && !sel_inv) |=> (lk_mask == $past(rf_rdata)));
    // R5
    inverted_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && sel_en && sel_inv) |=> (lk_mask == ~$past(rf_rdata)));
    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && sel_en) |=> (lk_zero == $past(sel_zero)));
endmodule

bind pred_mask_lookup pred_mask_lookup_chk #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_req   (lk_req),
    .sel_en   (sel_slot.en),
    .sel_inv  (sel_slot.inv),
    .sel_zero (sel_slot.zero),
    .rf_rdata (rf_rdata),
    .lk_valid (lk_valid),
    .lk_mask  (lk_mask),
    .lk_zero  (lk_zero)
);

// File: tb/pred_mask_lookup_tb_top.sv
// Bench: sweeps every slot of both files after each configuration phase,
// computing the expected mask from a bench-side table and register array.
module pred_mask_lookup_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [3:0]      cfg_addr = '0;
    logic [13:0]     cfg_wdata = '0;
    logic            lk_req = 1'b0;
    logic            lk_is_fp = 1'b0;
    logic [4:0]      lk_reg = '0;
    logic [4:0]      rf_raddr;
    logic [XLEN-1:0] rf_rdata;
    logic            lk_valid;
    logic [XLEN-1:0] lk_mask;
    logic            lk_zero;

    logic [XLEN-1:0] rf [32];
    logic [13:0]     model_cfg [16];
    int              n_tests = 0;
    int              n_fail = 0;
    string           phase = "reset";

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rf_rdata = rf[rf_raddr];

    pred_mask_lookup #(.XLEN(XLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .lk_req(lk_req), .lk_is_fp(lk_is_fp),
        .lk_reg(lk_reg), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .lk_valid(lk_valid), .lk_mask(lk_mask), .lk_zero(lk_zero)
    );

    task automatic check(input bit ok, input string req,
                         input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [phase %s] actual=%h expected=%h", req, phase, act, exp);
        end
    endtask

    // Build a word with the R2 field layout
    function automatic logic [13:0] mk(input bit bank, input bit zero, input bit inv,
                                       input bit fp, input int key, input int mreg);
        return {bank, zero, inv, fp, 5'(key), 5'(mreg)};
    endfunction

    task automatic write_cfg(input int addr, input logic [13:0] data);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = 4'(addr);
        cfg_wdata = data;
        model_cfg[addr] = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic lookup(input bit fp, input int r);
        bit found = 0;
        bit inv = 0;
        bit zr = 0;
        int idx = 0;
        logic [XLEN-1:0] exp_mask;
        logic [XLEN-1:0] held;
        for (int e = 0; e < 16; e++) begin
            if (!model_cfg[e][13] && model_cfg[e][10] == fp && int'(model_cfg[e][9:5]) == r) begin
                found = 1; zr = model_cfg[e][12]; inv = model_cfg[e][11]; idx = int'(model_cfg[e][4:0]);
            end
        end
        exp_mask = !found ? '1 : (inv ? ~rf[idx] : rf[idx]);
        lk_req = 1'b1; lk_is_fp = fp; lk_reg = 5'(r);
        @(negedge clk);
        lk_req = 1'b0;
        check(lk_valid === 1'b1, "R10", XLEN'(lk_valid), 1);
        check(lk_mask === exp_mask, !found ? "R3" : (inv ? "R5" : "R4"), lk_mask, exp_mask);
        check(lk_zero === (found & zr), "R6", XLEN'(lk_zero), XLEN'(found & zr));
        held = lk_mask;
        @(negedge clk);
        check(lk_valid === 1'b0 && lk_mask === held, "R10", lk_mask, held);
    endtask

    task automatic sweep();
        for (int f = 0; f < 2; f++)
            for (int r = 0; r < 32; r++) lookup(f[0], r);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) rf[i] = (32'h9E3779B9 * (i + 1)) ^ (i << 8);
        for (int e = 0; e < 16; e++) model_cfg[e] = 14'h2000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, all slots unpredicated
        phase = "R1 reset";
        sweep();

        // R2 R4 R5 R6: spread keys, mixed invert and zeroing; last write then immediate lookup (R9)
        phase = "R2 spread";
        for (int e = 0; e < 16; e++)
            write_cfg(e, mk(0, (e % 3) == 0, e[0], e[1], (e * 5) % 32, (e + 7) % 32));
        sweep();

        // R8 R7: many entries key float reg 9; top ones reserved; integer reg 9 too
        phase = "R8 duplicates";
        for (int e = 0; e < 16; e++) begin
            if (e >= 13)      write_cfg(e, mk(1, 1, 1, 1, 9, 31 - e));
            else if (e == 12) write_cfg(e, mk(0, 0, 0, 0, 9, 3));
            else              write_cfg(e, mk(0, e[0], e[1], 1, 9, e));
        end
        sweep();

        // R7: all entries reserved, each would target a distinct slot
        phase = "R7 reserved";
        for (int e = 0; e < 16; e++) write_cfg(e, mk(1, 1, 0, e[0], e, e));
        sweep();

        // R9: overwrite with new keys; old keys must vanish
        phase = "R9 rewrite";
        for (int e = 0; e < 16; e++) write_cfg(e, mk(0, 1, ~e[0], 0, 31 - e, e * 2));
        sweep();
        for (int e = 0; e < 16; e += 2) write_cfg(e, mk(0, 0, 1, 1, e, 30 - e));
        sweep();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule